// File: doc/BRIEF.md
# Capability Base Select and Address Check

This block is one stage of a capability-aware load/store pipeline. For each memory access it chooses the capability that authorizes the access, using a 5-bit base register index. It adds a sign-extended 12-bit immediate to that capability's address to form the effective address. It then checks the capability's tag and reports a tag-violation exception. The exception names a 6-bit capability register index built from the base index.

Base index zero does not stand for a null capability. Index zero is redirected. When the program-counter capability holds the system-register-access permission, the authorizing capability is the trap-data special capability. Without that permission, it is the program-counter capability itself.

The same selection serves data loads, data stores, capability loads and capability stores. The access kind travels with the result and does not affect it. The block drives the register-file read index and expects the register-file entry on the same cycle. The results are registered once and qualified by a valid flag.

Top module: `cap_ls_base_check`

## Requirements
- R1: When a request has a nonzero base index, the register-file read index equals that base index, and the registered authorizing capability (tag, permission bit, address) is the register-file entry presented with the request.
- R2: When a request has base index 0 and the program-counter capability's system-register-access bit is 1, the authorizing capability is the trap-data special capability.
- R3: When a request has base index 0 and the program-counter capability's system-register-access bit is 0, the authorizing capability is the program-counter capability.
- R4: The effective address is the authorizing address plus the immediate. Immediate bit 11 is the sign, so its range is -2048 to +2047. The sum wraps modulo 2^32 and has no overflow indication.
- R5: If the authorizing capability's tag is 0, out_exc is 1 and out_cause is 2'b10 (tag violation). If the tag is 1, out_exc is 0 and out_cause is 2'b00.
- R6: out_cap_idx is {1'b0, base index}.
- R7: The access kind (0 data load, 1 data store, 2 capability load, 3 capability store) has no effect on the selection, the address or the exception. It is echoed on out_kind.
- R8: Results appear on the clock edge that samples req_valid=1, with out_valid=1 for that cycle. After an edge that samples req_valid=0, out_valid, out_exc and out_cause are all 0.
- R9: A synchronous active-high reset sets out_valid to 0, out_exc to 0 and out_cause to 2'b00.
- R10: The program-counter and trap-data capabilities are taken as they are at the request edge. A later change to them leaves the registered result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_base_idx | input | 5 | Base capability register index |
| req_imm | input | 12 | Signed immediate offset |
| req_kind | input | 2 | Access kind, carried through |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_tag | input | 1 | Register-file entry tag |
| rf_sysreg_ok | input | 1 | Register-file entry system-register-access bit |
| rf_addr | input | 32 | Register-file entry address |
| pcc_tag | input | 1 | Program-counter capability tag |
| pcc_sysreg_ok | input | 1 | Program-counter capability system-register-access bit |
| pcc_addr | input | 32 | Program-counter capability address |
| tdc_tag | input | 1 | Trap-data capability tag |
| tdc_sysreg_ok | input | 1 | Trap-data capability system-register-access bit |
| tdc_addr | input | 32 | Trap-data capability address |
| out_valid | output | 1 | Result valid |
| out_tag | output | 1 | Authorizing capability tag |
| out_sysreg_ok | output | 1 | Authorizing capability system-register-access bit |
| out_addr | output | 32 | Authorizing capability address |
| out_eaddr | output | 32 | Effective address |
| out_exc | output | 1 | Exception raised |
| out_cause | output | 2 | Exception cause code |
| out_cap_idx | output | 6 | Capability register index for the exception |
| out_kind | output | 2 | Access kind echo |

## Verification
Every result of a request is held in a single register stage. The selected capability, effective address, exception flag, cause, index and kind are therefore all due on the rising edge that samples req_valid. The register-file read index is combinational and is due in the same cycle. The bench drives a request at the falling edge, waits for the next rising edge and samples 1 ns after it. The drop of out_valid and of the exception outputs is sampled one edge later. The sampling-time test changes the program-counter and trap-data inputs just after the capture edge and rereads the outputs before the next edge.

// File: rtl/cap_ls_pkg.sv
package cap_ls_pkg;

    localparam int XLEN   = 32;
    localparam int IDX_W  = 5;
    localparam int IMM_W  = 12;
    localparam int KIND_W = 2;
    localparam int CIDX_W = IDX_W + 1;

    typedef struct packed {
        logic            tag;
        logic            sysreg_ok;
        logic [XLEN-1:0] addr;
    } cap_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_TAG  = 2'b10
    } cause_e;

    typedef struct packed {
        cap_t              cap;
        logic [XLEN-1:0]   eaddr;
        logic              exc;
        cause_e            cause;
        logic [CIDX_W-1:0] cidx;
        logic [KIND_W-1:0] kind;
    } result_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/cap_base_select.sv
module cap_base_select
    import cap_ls_pkg::*;
(
    input  logic [IDX_W-1:0] base_idx,
    input  cap_t             rf_cap,
    input  cap_t             pcc_cap,
    input  cap_t             tdc_cap,
    output cap_t             auth_cap
);
    logic idx_is_zero;
    assign idx_is_zero = (base_idx == '0);

    always_comb begin
        if (!idx_is_zero)
            auth_cap = rf_cap;
        else if (pcc_cap.sysreg_ok)
            auth_cap = tdc_cap;
        else
            auth_cap = pcc_cap;
    end
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen
    import cap_ls_pkg::*;
(
    input  logic [XLEN-1:0]  base_addr,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  eaddr
);
    // Modular sum; any carry out of the top bit is discarded.
    assign eaddr = base_addr + widen_imm(imm);
endmodule

// File: rtl/cap_tag_check.sv
module cap_tag_check
    import cap_ls_pkg::*;
(
    input  logic              auth_tag,
    input  logic [IDX_W-1:0]  base_idx,
    output logic              exc,
    output cause_e            cause,
    output logic [CIDX_W-1:0] cidx
);
    always_comb begin
        exc   = !auth_tag;
        cause = auth_tag ? CAUSE_NONE : CAUSE_TAG;
        cidx  = {1'b0, base_idx};
    end
endmodule

// File: rtl/cap_ls_base_check.sv
module cap_ls_base_check
    import cap_ls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_base_idx,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [KIND_W-1:0] req_kind,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic              rf_tag,
    input  logic              rf_sysreg_ok,
    input  logic [XLEN-1:0]   rf_addr,
    input  logic              pcc_tag,
    input  logic              pcc_sysreg_ok,
    input  logic [XLEN-1:0]   pcc_addr,
    input  logic              tdc_tag,
    input  logic              tdc_sysreg_ok,
    input  logic [XLEN-1:0]   tdc_addr,
    output logic              out_valid,
    output logic              out_tag,
    output logic              out_sysreg_ok,
    output logic [XLEN-1:0]   out_addr,
    output logic [XLEN-1:0]   out_eaddr,
    output logic              out_exc,
    output logic [1:0]        out_cause,
    output logic [CIDX_W-1:0] out_cap_idx,
    output logic [KIND_W-1:0] out_kind
);
    cap_t    rf_cap, pcc_cap, tdc_cap, auth_cap;
    result_t nxt, res_q;
    logic    valid_q;

    assign rf_rd_idx = req_base_idx;
    assign rf_cap    = '{tag: rf_tag,  sysreg_ok: rf_sysreg_ok,  addr: rf_addr};
    assign pcc_cap   = '{tag: pcc_tag, sysreg_ok: pcc_sysreg_ok, addr: pcc_addr};
    assign tdc_cap   = '{tag: tdc_tag, sysreg_ok: tdc_sysreg_ok, addr: tdc_addr};

    cap_base_select u_sel (
        .base_idx (req_base_idx),
        .rf_cap   (rf_cap),
        .pcc_cap  (pcc_cap),
        .tdc_cap  (tdc_cap),
        .auth_cap (auth_cap)
    );

    cap_addr_gen u_agen (
        .base_addr (auth_cap.addr),
        .imm       (req_imm),
        .eaddr     (nxt.eaddr)
    );

    cap_tag_check u_tchk (
        .auth_tag (auth_cap.tag),
        .base_idx (req_base_idx),
        .exc      (nxt.exc),
        .cause    (nxt.cause),
        .cidx     (nxt.cidx)
    );

    assign nxt.cap  = auth_cap;
    assign nxt.kind = req_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q     <= 1'b0;
            res_q.exc   <= 1'b0;
            res_q.cause <= CAUSE_NONE;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                res_q <= nxt;
            end else begin
                res_q.exc   <= 1'b0;
                res_q.cause <= CAUSE_NONE;
            end
        end
    end

    assign out_valid     = valid_q;
    assign out_tag       = res_q.cap.tag;
    assign out_sysreg_ok = res_q.cap.sysreg_ok;
    assign out_addr      = res_q.cap.addr;
    assign out_eaddr     = res_q.eaddr;
    assign out_exc       = res_q.exc;
    assign out_cause     = res_q.cause;
    assign out_cap_idx   = res_q.cidx;
    assign out_kind      = res_q.kind;
endmodule

// File: rtl/cap_ls_base_check_sva.sv
module cap_ls_base_check_sva
    import cap_ls_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_base_idx,
    input logic [IMM_W-1:0]  req_imm,
    input logic [IDX_W-1:0]  rf_rd_idx,
    input logic              rf_tag,
    input logic [XLEN-1:0]   rf_addr,
    input logic              pcc_sysreg_ok,
    input logic [XLEN-1:0]   pcc_addr,
    input logic [XLEN-1:0]   tdc_addr,
    input logic              out_valid,
    input logic              out_tag,
    input logic [XLEN-1:0]   out_addr,
    input logic [XLEN-1:0]   out_eaddr,
    input logic              out_exc,
    input logic [1:0]        out_cause,
    input logic [CIDX_W-1:0] out_cap_idx
);
    assert_rf_pick_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_base_idx != '0) |=>
            (out_addr == $past(rf_addr) && out_tag == $past(rf_tag)));

    assert_rd_idx_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (rf_rd_idx == req_base_idx));

    assert_tdc_pick_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_base_idx == '0 && pcc_sysreg_ok) |=>
            (out_addr == $past(tdc_addr)));

    assert_pcc_pick_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_base_idx == '0 && !pcc_sysreg_ok) |=>
            (out_addr == $past(pcc_addr)));

    assert_eaddr_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=>
            (out_eaddr == out_addr + {{(XLEN-IMM_W){$past(req_imm[IMM_W-1])}}, $past(req_imm)}));

    assert_tag_exc_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tag) |-> (out_exc && out_cause == 2'b10));

    assert_no_exc_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag) |-> (!out_exc && out_cause == 2'b00));

    assert_cidx_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_cap_idx == {1'b0, $past(req_base_idx)}));

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_valid_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !out_exc && out_cause == 2'b00));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_exc && out_cause == 2'b00));
endmodule

bind cap_ls_base_check cap_ls_base_check_sva chk_i (.*);

// File: tb/cap_ls_base_check_tb_top.sv
module cap_ls_base_check_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [4:0]  req_base_idx;
    logic [11:0] req_imm;
    logic [1:0]  req_kind;
    logic [4:0]  rf_rd_idx;
    logic        rf_tag, rf_sysreg_ok;
    logic [31:0] rf_addr;
    logic        pcc_tag, pcc_sysreg_ok;
    logic [31:0] pcc_addr;
    logic        tdc_tag, tdc_sysreg_ok;
    logic [31:0] tdc_addr;
    logic        out_valid, out_tag, out_sysreg_ok, out_exc;
    logic [31:0] out_addr, out_eaddr;
    logic [1:0]  out_cause, out_kind;
    logic [5:0]  out_cap_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cap_ls_base_check dut_i (.*);

    localparam logic [31:0] RF_A  = 32'h1000_0000;
    localparam logic [31:0] PCC_A = 32'h2000_0000;
    localparam logic [31:0] TDC_A = 32'h3000_0000;

    // idx, imm, kind, rf_tag, pcc_tag, pcc_ok, tdc_tag, exp_eaddr, exp_src(0 rf,1 tdc,2 pcc), exp_exc
    typedef struct packed {
        logic [4:0]  idx;
        logic [11:0] imm;
        logic [1:0]  kind;
        logic        rft, pct, pco, tdt;
        logic [31:0] eaddr;
        logic [1:0]  src;
        logic        exc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{5'd5,  12'h004, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h1000_0004, 2'd0, 1'b0},
        '{5'd31, 12'hFFF, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0FFF_FFFF, 2'd0, 1'b0},
        '{5'd0,  12'h010, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 32'h3000_0010, 2'd1, 1'b0},
        '{5'd0,  12'h800, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1FFF_F800, 2'd2, 1'b0},
        '{5'd0,  12'h7FF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h3000_07FF, 2'd1, 1'b1},
        '{5'd7,  12'h000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1000_0000, 2'd0, 1'b1},
        '{5'd0,  12'h001, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 32'h2000_0001, 2'd2, 1'b1},
        '{5'd1,  12'h100, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 32'h1000_0100, 2'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] idx, input logic [11:0] imm, input logic [1:0] kind);
        @(negedge clk);
        req_valid    = 1'b1;
        req_base_idx = idx;
        req_imm      = imm;
        req_kind     = kind;
        #1;
        chk("R1 rf_rd_idx", {27'd0, rf_rd_idx}, {27'd0, idx});
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_base_idx = '0; req_imm = '0; req_kind = '0;
        rf_tag = 1'b1; rf_sysreg_ok = 1'b0; rf_addr = RF_A;
        pcc_tag = 1'b1; pcc_sysreg_ok = 1'b0; pcc_addr = PCC_A;
        tdc_tag = 1'b1; tdc_sysreg_ok = 1'b1; tdc_addr = TDC_A;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R9 reset exc",   {31'd0, out_exc},   32'd0);
        chk("R9 reset cause", {30'd0, out_cause}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] ea;
            logic        et;
            @(negedge clk);
            rf_tag = VT[i].rft; pcc_tag = VT[i].pct; pcc_sysreg_ok = VT[i].pco; tdc_tag = VT[i].tdt;
            drive(VT[i].idx, VT[i].imm, VT[i].kind);
            ea = (VT[i].src == 2'd0) ? RF_A  : (VT[i].src == 2'd1) ? TDC_A : PCC_A;
            et = (VT[i].src == 2'd0) ? VT[i].rft : (VT[i].src == 2'd1) ? VT[i].tdt : VT[i].pct;
            chk("R8 valid",             {31'd0, out_valid}, 32'd1);
            chk("R1/R2/R3 source addr", out_addr, ea);
            chk("R1/R2/R3 source tag",  {31'd0, out_tag}, {31'd0, et});
            chk("R4 eaddr",             out_eaddr, VT[i].eaddr);
            chk("R5 exc",               {31'd0, out_exc}, {31'd0, VT[i].exc});
            chk("R5 cause",             {30'd0, out_cause}, VT[i].exc ? 32'd2 : 32'd0);
            chk("R6 cap idx",           {26'd0, out_cap_idx}, {27'd0, VT[i].idx});
            chk("R7 kind",              {30'd0, out_kind}, {30'd0, VT[i].kind});
        end

        // R8: idle cycle clears valid and exception
        @(posedge clk); #1;
        chk("R8 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R8 idle exc",   {31'd0, out_exc},   32'd0);

        // R4: wrap-around both directions
        @(negedge clk); rf_tag = 1'b1; rf_addr = 32'hFFFF_FFF0;
        drive(5'd3, 12'h020, 2'd0);
        chk("R4 wrap up", out_eaddr, 32'h0000_0010);
        @(negedge clk); rf_addr = 32'h0000_0004;
        drive(5'd3, 12'hFF8, 2'd0);
        chk("R4 wrap down", out_eaddr, 32'hFFFF_FFFC);

        // R2/R1: the trap-data permission bit comes through with the selection
        @(negedge clk); pcc_sysreg_ok = 1'b1; tdc_sysreg_ok = 1'b1; tdc_tag = 1'b1;
        drive(5'd0, 12'h000, 2'd1);
        chk("R2 perm bit", {31'd0, out_sysreg_ok}, 32'd1);
        @(negedge clk); rf_sysreg_ok = 1'b0;
        drive(5'd9, 12'h000, 2'd1);
        chk("R1 perm bit", {31'd0, out_sysreg_ok}, 32'd0);

        // R7: same request under every kind gives the same address and exception
        @(negedge clk); rf_addr = 32'h0000_1000; rf_tag = 1'b0;
        for (int k = 0; k < 4; k++) begin
            drive(5'd12, 12'h00C, k[1:0]);
            chk("R7 addr kind-free", out_eaddr, 32'h0000_100C);
            chk("R7 exc kind-free",  {31'd0, out_exc}, 32'd1);
        end

        // R10: change pcc/tdc after the capture edge
        @(negedge clk); pcc_sysreg_ok = 1'b0; pcc_addr = 32'h4444_0000; pcc_tag = 1'b1;
        drive(5'd0, 12'h004, 2'd0);
        pcc_addr = 32'h5555_0000; pcc_sysreg_ok = 1'b1; tdc_addr = 32'h6666_0000;
        #2;
        chk("R10 held addr",  out_addr,  32'h4444_0000);
        chk("R10 held eaddr", out_eaddr, 32'h4444_0004);

        // R9: reset right after an excepting result
        @(negedge clk); rf_tag = 1'b0;
        drive(5'd2, 12'h000, 2'd0);
        chk("R5 exc before reset", {31'd0, out_exc}, 32'd1);
        @(negedge clk); rst = 1'b1; req_valid = 1'b1;
        @(posedge clk); #1;
        chk("R9 reset clears valid", {31'd0, out_valid}, 32'd0);
        chk("R9 reset clears exc",   {31'd0, out_exc},   32'd0);
        chk("R9 reset clears cause", {30'd0, out_cause}, 32'd0);
        @(negedge clk); rst = 1'b0; req_valid = 1'b0;
        @(posedge clk); #1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule